// File: doc/BRIEF.md
# Memory Power-Down Entry and Exit Sequencer

This block sits on the controller side of a DDR2-style memory interface. It owns the clock-enable pin and the command bus. Its job is to decide when clock enable may be lowered to put the memory into power-down, and when normal commands may resume after clock enable goes high again. The controller presents one-cycle request strobes for activate, precharge, write with auto-precharge, power-down and wake. The sequencer accepts a command strobe only while its ready flag is high, and it places the encoded command on the bus one cycle later.

While a delay is running, the block drives only no-operation codes. Two kinds of delay exist. An entry delay follows each precharge or write with auto-precharge. An exit delay follows the rise of clock enable. A one-bit tracker records whether a bank is open. That tracker selects between active power-down, which uses the fast or slow exit time chosen by a mode bit, and precharge power-down, which uses the precharge exit time.

A power-down request that arrives while an entry delay is counting is held. It is granted on the edge where that delay runs out, unless a wake request cancels it first. All timing values are run-time inputs that load 5-bit down-counters. A computed write entry delay that does not fit in 5 bits is clamped to 31.

Top module: `pd_sequencer`

## Requirements
- R1: After synchronous reset, `cke` is 1, `cmd_bus` is the no-operation code 4'b0111 and `ready` is 1.
- R2: `cmd_bus` carries {cs_n, ras_n, cas_n, we_n}, with NOP = 4'b0111, activate = 4'b0011, precharge = 4'b0010 and write with auto-precharge = 4'b0100. A strobe sampled while `ready` is 1 appears on `cmd_bus` for exactly the following cycle. When several strobes are high together, one is accepted, in the order precharge, then write with auto-precharge, then activate, then power-down request.
- R3: Command strobes sampled while `ready` is 0 are dropped, so `cmd_bus` stays NOP. While `cke` is 0, `cmd_bus` is always NOP.
- R4: An accepted write with auto-precharge holds `ready` low for (rd_lat-1) + (4 if `burst8` else 2) + `wr_rec` cycles, followed by `t_rp` further cycles, counted from the cycle the write appears on `cmd_bus`. It then records the bank as closed.
- R5: An accepted precharge holds `ready` low for `t_rp` cycles, counted from the cycle it appears on `cmd_bus`, and records the bank as closed.
- R6: A power-down request sampled while an entry delay counts is held. `cke` goes low exactly when the total entry delay has elapsed, with the delay counted from the cycle the triggering command appeared on `cmd_bus`.
- R7: A wake request sampled while a power-down request is held cancels it, so `cke` stays 1. A wake request while `cke` is 1 and nothing is held has no effect.
- R8: A power-down request sampled while `ready` is 1 makes `cke` 0 in the next cycle and `ready` 0. A power-down request sampled while an exit delay counts is ignored.
- R9: With a bank open, power-down is active power-down. `cke` stays 0 until a wake request. After wake, `ready` is first 1 `t_xard` cycles after the cycle in which `cke` is first 1 if `slow_exit` is 0, or `t_xards` cycles after that cycle if `slow_exit` is 1.
- R10: With all banks closed, power-down is precharge power-down. `ready` is first 1 `t_xp` cycles after the cycle in which `cke` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_act | input | 1 | Activate request strobe |
| cmd_pre | input | 1 | Precharge request strobe |
| cmd_wrap | input | 1 | Write with auto-precharge request strobe |
| pd_req | input | 1 | Power-down request strobe |
| wake_req | input | 1 | Wake (power-down exit) request strobe |
| rd_lat | input | 5 | Read latency in cycles; write latency is one less |
| burst8 | input | 1 | 1 = burst length 8, 0 = burst length 4 |
| wr_rec | input | 5 | Write recovery cycles |
| t_rp | input | 5 | Precharge period cycles |
| t_xp | input | 5 | Exit delay from precharge power-down |
| t_xard | input | 5 | Fast exit delay from active power-down |
| t_xards | input | 5 | Slow exit delay from active power-down |
| slow_exit | input | 1 | Selects the slow active power-down exit |
| cke | output | 1 | Clock enable, registered one cycle ahead of use |
| cmd_bus | output | 4 | {cs_n, ras_n, cas_n, we_n} command code |
| ready | output | 1 | High when new commands may be accepted |

## Verification
An accepted command is due on `cmd_bus` one cycle after its strobe is sampled, and a power-down grant from the ready state is due on `cke` one cycle after its strobe is sampled. A held power-down request lowers `cke` exactly R4 or R5's total delay after the command was shown. After wake, `ready` rises exactly the chosen exit count of cycles after `cke` first reads high. The bench samples on the falling edge and drives strobes for one full cycle. For the delays it checks `ready` or `cke` in every intermediate cycle and then in the first cycle where the change is due, so both an early change and a late change are reported.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

    localparam int CNT_W = 5;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam dram_cmd_t CMD_ACT = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
    localparam dram_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam dram_cmd_t CMD_WRA = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};

    typedef enum logic [1:0] {
        PWR_UP     = 2'd0,
        PWR_DN_ACT = 2'd1,
        PWR_DN_PRE = 2'd2
    } pwr_state_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WRAP = 2'd1,
        PH_TRP  = 2'd2
    } ent_phase_e;

    // write latency + half burst + write recovery, clamped to the counter range
    function automatic cnt_t wrap_entry_delay(cnt_t rl, logic bl8, cnt_t wr);
        logic [CNT_W+1:0] sum;
        cnt_t             wl;
        wl  = (rl == '0) ? '0 : rl - 1'b1;
        sum = {2'b00, wl} + {2'b00, wr} + (bl8 ? (CNT_W+2)'(4) : (CNT_W+2)'(2));
        if (sum > {2'b00, {CNT_W{1'b1}}})
            return '1;
        return sum[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/pd_down_counter.sv
module pd_down_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         busy
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign busy = (count != '0);

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && count != '0) |=> (count == $past(count) - 1'b1));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && count == '0) |=> (count == '0));

endmodule

// File: rtl/pd_delay_select.sv
module pd_delay_select
    import pd_seq_pkg::*;
(
    input  cnt_t rd_lat,
    input  logic burst8,
    input  cnt_t wr_rec,
    input  cnt_t t_xp,
    input  cnt_t t_xard,
    input  cnt_t t_xards,
    input  logic slow_exit,
    input  logic from_active,
    output cnt_t wrap_ld,
    output cnt_t exit_ld
);

    assign wrap_ld = wrap_entry_delay(rd_lat, burst8, wr_rec);

    always_comb begin
        if (!from_active)
            exit_ld = t_xp;
        else if (slow_exit)
            exit_ld = t_xards;
        else
            exit_ld = t_xard;
    end

endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
    import pd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_act,
    input  logic       cmd_pre,
    input  logic       cmd_wrap,
    input  logic       pd_req,
    input  logic       wake_req,
    input  logic [4:0] rd_lat,
    input  logic       burst8,
    input  logic [4:0] wr_rec,
    input  logic [4:0] t_rp,
    input  logic [4:0] t_xp,
    input  logic [4:0] t_xard,
    input  logic [4:0] t_xards,
    input  logic       slow_exit,
    output logic       cke,
    output logic [3:0] cmd_bus,
    output logic       ready
);

    pwr_state_e state_q;
    ent_phase_e phase_q;
    dram_cmd_t  cmd_q;
    logic       bank_q;
    logic       pend_q;

    cnt_t ent_cnt, exit_cnt, ent_ld_val, wrap_ld, exit_ld;
    logic ent_busy, exit_busy, ent_load, exit_load;

    logic acc_pre, acc_wrap, acc_act, enter_now, phase_end, grant_pend, in_pd;

    pd_delay_select u_sel (
        .rd_lat      (rd_lat),
        .burst8      (burst8),
        .wr_rec      (wr_rec),
        .t_xp        (t_xp),
        .t_xard      (t_xard),
        .t_xards     (t_xards),
        .slow_exit   (slow_exit),
        .from_active (state_q == PWR_DN_ACT),
        .wrap_ld     (wrap_ld),
        .exit_ld     (exit_ld)
    );

    pd_down_counter #(.W(CNT_W)) u_entry (
        .clk      (clk),
        .rst      (rst),
        .load     (ent_load),
        .load_val (ent_ld_val),
        .count    (ent_cnt),
        .busy     (ent_busy)
    );

    pd_down_counter #(.W(CNT_W)) u_exit (
        .clk      (clk),
        .rst      (rst),
        .load     (exit_load),
        .load_val (exit_ld),
        .count    (exit_cnt),
        .busy     (exit_busy)
    );

    assign in_pd = (state_q != PWR_UP);
    assign ready = !in_pd && (phase_q == PH_IDLE) && !ent_busy && !exit_busy;

    // request arbitration, fixed priority
    assign acc_pre   = ready && cmd_pre;
    assign acc_wrap  = ready && cmd_wrap && !cmd_pre;
    assign acc_act   = ready && cmd_act && !cmd_pre && !cmd_wrap;
    assign enter_now = ready && pd_req && !cmd_pre && !cmd_wrap && !cmd_act;

    assign phase_end  = (phase_q != PH_IDLE) && (ent_cnt <= cnt_t'(1));
    assign grant_pend = phase_end && (phase_q == PH_TRP) && (pend_q || pd_req) && !wake_req;

    always_comb begin
        ent_load   = 1'b0;
        ent_ld_val = t_rp;
        if (acc_pre) begin
            ent_load   = 1'b1;
            ent_ld_val = t_rp;
        end else if (acc_wrap) begin
            ent_load   = 1'b1;
            ent_ld_val = wrap_ld;
        end else if (phase_end && phase_q == PH_WRAP) begin
            ent_load   = 1'b1;
            ent_ld_val = t_rp;
        end
    end

    assign exit_load = in_pd && wake_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWR_UP;
            phase_q <= PH_IDLE;
            cmd_q   <= CMD_NOP;
            bank_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            // command bus
            if (acc_pre)
                cmd_q <= CMD_PRE;
            else if (acc_wrap)
                cmd_q <= CMD_WRA;
            else if (acc_act)
                cmd_q <= CMD_ACT;
            else
                cmd_q <= CMD_NOP;

            // entry phase tracking
            if (acc_pre)
                phase_q <= PH_TRP;
            else if (acc_wrap)
                phase_q <= PH_WRAP;
            else if (phase_end)
                phase_q <= (phase_q == PH_WRAP) ? PH_TRP : PH_IDLE;

            // open-bank tracker
            if (acc_act)
                bank_q <= 1'b1;
            else if (acc_pre || (phase_end && phase_q == PH_WRAP))
                bank_q <= 1'b0;

            // held power-down request
            if (in_pd || wake_req || grant_pend)
                pend_q <= 1'b0;
            else if (pd_req && phase_q != PH_IDLE)
                pend_q <= 1'b1;

            // clock-enable state
            if (!in_pd) begin
                if (enter_now || grant_pend)
                    state_q <= bank_q ? PWR_DN_ACT : PWR_DN_PRE;
            end else if (wake_req) begin
                state_q <= PWR_UP;
            end
        end
    end

    assign cke     = !in_pd;
    assign cmd_bus = cmd_q;

    // R3
    nop_while_low_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (cmd_bus == CMD_NOP));

    // R2
    cmd_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_bus != CMD_NOP) |-> $past(ready));

    // R6
    pend_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> (phase_q != PH_IDLE));

    // R8
    cke_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (ent_cnt == '0 && !exit_busy));

    // R9
    stay_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke && !wake_req) |=> !cke);

    // R10
    ready_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (cke && !exit_busy));

endmodule

// File: tb/tb_pd_sequencer.sv
module tb_pd_sequencer;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] ACT = 4'b0011;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] WRA = 4'b0100;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_act, cmd_pre, cmd_wrap, pd_req, wake_req;
    logic [4:0] rd_lat, wr_rec, t_rp, t_xp, t_xard, t_xards;
    logic       burst8, slow_exit;
    logic       cke, ready;
    logic [3:0] cmd_bus;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pd_sequencer dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_act   (cmd_act),
        .cmd_pre   (cmd_pre),
        .cmd_wrap  (cmd_wrap),
        .pd_req    (pd_req),
        .wake_req  (wake_req),
        .rd_lat    (rd_lat),
        .burst8    (burst8),
        .wr_rec    (wr_rec),
        .t_rp      (t_rp),
        .t_xp      (t_xp),
        .t_xard    (t_xard),
        .t_xards   (t_xards),
        .slow_exit (slow_exit),
        .cke       (cke),
        .cmd_bus   (cmd_bus),
        .ready     (ready)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ready_exact(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            chk(req, "ready still low", int'(ready), 0);
            tick();
        end
        chk(req, "ready rises on time", int'(ready), 1);
    endtask

    function automatic int wrap_total();
        return (int'(rd_lat) - 1) + (burst8 ? 4 : 2) + int'(wr_rec) + int'(t_rp);
    endfunction

    task automatic test_reset();
        chk("R1", "cke after reset", int'(cke), 1);
        chk("R1", "cmd after reset", int'(cmd_bus), int'(NOP));
        chk("R1", "ready after reset", int'(ready), 1);
    endtask

    task automatic test_priority_and_act();
        cmd_pre = 1'b1; cmd_act = 1'b1;
        tick();
        cmd_pre = 1'b0; cmd_act = 1'b0;
        chk("R2", "precharge wins over activate", int'(cmd_bus), int'(PRE));
        wait_ready_exact(int'(t_rp), "R5");
        cmd_act = 1'b1; pd_req = 1'b1;
        tick();
        cmd_act = 1'b0; pd_req = 1'b0;
        chk("R2", "activate shown", int'(cmd_bus), int'(ACT));
        chk("R2", "activate wins over power-down", int'(cke), 1);
        tick();
        chk("R2", "single cycle command", int'(cmd_bus), int'(NOP));
    endtask

    task automatic test_active_pd();
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        chk("R8", "cke low after request", int'(cke), 0);
        chk("R8", "ready low in power-down", int'(ready), 0);
        cmd_act = 1'b1;
        tick();
        cmd_act = 1'b0;
        chk("R3", "no command in power-down", int'(cmd_bus), int'(NOP));
        tick();
        chk("R9", "cke stays low without wake", int'(cke), 0);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        chk("R9", "cke high after wake", int'(cke), 1);
        wait_ready_exact(int'(t_xard), "R9");
        slow_exit = 1'b1;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        chk("R9", "cke low, slow mode", int'(cke), 0);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        wait_ready_exact(int'(t_xards), "R9");
        slow_exit = 1'b0;
    endtask

    task automatic test_wrap();
        int n;
        n = wrap_total();
        cmd_wrap = 1'b1;
        tick();
        cmd_wrap = 1'b0;
        chk("R2", "write with auto-precharge shown", int'(cmd_bus), int'(WRA));
        cmd_act = 1'b1;
        tick();
        cmd_act = 1'b0;
        chk("R3", "strobe dropped while busy", int'(cmd_bus), int'(NOP));
        wait_ready_exact(n - 1, "R4");
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        chk("R4", "power-down entered", int'(cke), 0);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        wait_ready_exact(int'(t_xp), "R10");
    endtask

    task automatic test_pre_pending();
        cmd_pre = 1'b1;
        tick();
        cmd_pre = 1'b0;
        chk("R5", "precharge shown", int'(cmd_bus), int'(PRE));
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        chk("R6", "cke held during tRP", int'(cke), 1);
        for (int k = 2; k < int'(t_rp); k++) begin
            tick();
            chk("R6", "cke held during tRP", int'(cke), 1);
        end
        tick();
        chk("R6", "cke drops at tRP", int'(cke), 0);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        wait_ready_exact(int'(t_xp), "R10");
    endtask

    task automatic test_wrap_pending();
        int n;
        rd_lat = 5'd4; burst8 = 1'b1; wr_rec = 5'd2;
        n = wrap_total();
        cmd_act = 1'b1;
        tick();
        cmd_act = 1'b0;
        cmd_wrap = 1'b1;
        tick();
        cmd_wrap = 1'b0;
        chk("R4", "write with auto-precharge shown", int'(cmd_bus), int'(WRA));
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        chk("R6", "cke held after write", int'(cke), 1);
        for (int k = 2; k < n; k++) begin
            tick();
            chk("R6", "cke held during write delay", int'(cke), 1);
        end
        tick();
        chk("R6", "cke drops after write delay", int'(cke), 0);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        wait_ready_exact(int'(t_xp), "R10");
        rd_lat = 5'd3; burst8 = 1'b0; wr_rec = 5'd3;
    endtask

    task automatic test_cancel_and_ignore();
        cmd_pre = 1'b1;
        tick();
        cmd_pre = 1'b0;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        for (int k = 3; k <= int'(t_rp); k++) begin
            chk("R7", "cancelled request keeps cke", int'(cke), 1);
            tick();
        end
        chk("R7", "cke high after cancel", int'(cke), 1);
        chk("R7", "ready after cancel", int'(ready), 1);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        chk("R7", "idle wake leaves cke", int'(cke), 1);
        chk("R7", "idle wake leaves ready", int'(ready), 1);
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        chk("R8", "request during exit ignored", int'(cke), 1);
        wait_ready_exact(int'(t_xp) - 1, "R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cmd_act = 1'b0; cmd_pre = 1'b0; cmd_wrap = 1'b0;
        pd_req = 1'b0; wake_req = 1'b0;
        rd_lat = 5'd3; burst8 = 1'b0; wr_rec = 5'd3;
        t_rp = 5'd4; t_xp = 5'd3; t_xard = 5'd2; t_xards = 5'd6;
        slow_exit = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        test_reset();
        test_priority_and_act();
        test_active_pd();
        test_wrap();
        test_pre_pending();
        test_wrap_pending();
        test_cancel_and_ignore();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule